// File: doc/BRIEF.md
# Multi-rate TDM serial stream transmitter

This block drives a set of serial time-division-multiplexed output streams that share one frame pulse. Each stream has its own four-bit rate code, so the lanes can run at different rates in the same frame. Each channel carries one byte, sent most significant bit first. Every channel slot costs one byte from an outside data source. One cycle before a channel's first bit, the lane raises a read request that carries the channel number. The source answers in that same cycle with the byte and a per-channel output-enable, and the lane loads the answer on the channel boundary.

`clk` is the bit-slot clock at 16.384 MHz. One cycle is one bit at the fastest rate, and a frame lasts `BASE_CH*64` cycles. In multiplied mode every rate is available. In divided mode the outputs follow the input clock, whose frequency is given by `ckin_code`. A rate faster than half that frequency is then illegal, and the lane stays high-impedance. Only the lower `HZ_N` streams have a separate high-impedance control pin for an external tristate driver.

The request is a stream that cannot stall. It has no ready, so there is no back-pressure. A source that cannot answer holds `rsp_valid` low in the request cycle, and the lane then sends that channel high-impedance instead of waiting.

Top module: `tdm_mrate_tx`

## Requirements
- R1: After reset, and until the first frame pulse, every `ser_oe` is 0, every `hz_o` is 1 and no `req_valid` is raised.
- R2: Rate code c in 0..3 gives a bit period of 8>>c cycles and `BASE_CH<<c` channels per frame. The codes mean 2.048, 4.096, 8.192 and 16.384 Mbps.
- R3: `req_valid[s]` is high in exactly the cycle before each channel's first bit, with `req_chan` equal to that channel's index. The request for channel 0 falls in the cycle where `frame_i` is high.
- R4: A loaded byte appears on `ser_o` most significant bit first. Each bit is held for one bit period.
- R5: If `rsp_oe` is 0 in the request cycle, the whole channel has `ser_oe`=0 and `ser_o`=0, whatever its data.
- R6: If `rsp_valid` is 0 in the request cycle, the channel is sent high-impedance (`ser_oe`=0).
- R7: With `div_mode`=1, a code c above `ckin_code` is illegal. `ckin_code` 0..3 means an input clock of 4.096, 8.192, 16.384 or 32.768 MHz. An illegal lane raises no request and keeps `ser_oe`=0. With `div_mode`=0, all of codes 0..3 are legal.
- R8: Rate codes 4..15 are illegal in both modes and behave as in R7.
- R9: `rate_cfg`, `div_mode` and `ckin_code` are sampled only in a cycle where `frame_i` is high. Changing them in the middle of a frame does not affect that frame.
- R10: For streams below `HZ_N`, `hz_o[s]` is the inverse of `ser_oe[s]`. The other streams have no such pin.
- R11: The lanes run independently, so each stream follows its own rate code within the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz bit-slot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame pulse, high in the cycle before slot 0 |
| div_mode | input | 1 | 1 = divided clock mode, 0 = multiplied |
| ckin_code | input | 2 | Input clock frequency code used in divided mode |
| rate_cfg | input | 4*N_STR | Per-stream rate code, stream s at bits [4s+3:4s] |
| req_valid | output | N_STR | Byte request per stream |
| req_chan | output | CHW*N_STR | Requested channel index per stream |
| rsp_valid | input | N_STR | Response present in the request cycle |
| rsp_data | input | 8*N_STR | Response byte per stream |
| rsp_oe | input | N_STR | Response per-channel output-enable |
| ser_o | output | N_STR | Serial data per stream |
| ser_oe | output | N_STR | Per-stream pin drive enable |
| hz_o | output | HZ_N | High-impedance control for streams 0..HZ_N-1 |

## Verification
The bench builds the block with four streams, two tristate control pins and `BASE_CH`=2. That makes a frame 128 cycles long, with 2 to 16 channels per stream. At that size the bench can step through every ordered pair of mode and input clock code, and for each pair several mixes of legal and illegal rate codes, all within a few thousand cycles. It predicts every output bit, enable and request in every slot from arithmetic on the slot number. Its responder marks some channels disabled or missing and changes the configuration in the middle of some frames, so the enable rules and the per-frame sampling are both exercised.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SLOTS_PER_BASE_CH = 64;

  typedef logic [CODE_W-1:0] rate_code_t;

  // legal: upper code bits clear, and in divided mode no faster than ck code
  function automatic logic rate_legal(input rate_code_t code, input logic div, input logic [1:0] ck);
    return (code[3:2] == 2'b00) && (!div || (code[1:0] <= ck));
  endfunction
endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_i,
  output logic [CNT_W-1:0] slot_nxt,
  output logic             run_nxt
);
  logic [CNT_W-1:0] slot_q;
  logic             run_q;

  assign slot_nxt = frame_i ? '0 : slot_q + CNT_W'(1);
  assign run_nxt  = run_q | frame_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      run_q  <= 1'b0;
    end else begin
      slot_q <= slot_nxt;
      run_q  <= run_nxt;
    end
  end
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned CHW   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            run_nxt,
  input  logic [CNT_W-1:0]                slot_nxt,
  input  logic [1:0]                      rate_nxt,
  input  logic                            legal_nxt,
  output logic                            req_valid,
  output logic [CHW-1:0]                  req_chan,
  input  logic                            rsp_valid,
  input  logic [tdm_tx_pkg::BYTE_W-1:0]   rsp_data,
  input  logic                            rsp_oe,
  output logic                            ser_o,
  output logic                            ser_oe
);
  import tdm_tx_pkg::*;

  logic [CNT_W-1:0]  ch_mask, bit_mask, ch_full;
  logic [2:0]        ch_shift, bit_shift;
  logic              ch_start, bit_start;
  logic [BYTE_W-1:0] sh_q;
  logic              oe_q;

  always_comb begin
    ch_shift  = 3'd6 - {1'b0, rate_nxt};
    bit_shift = 3'd3 - {1'b0, rate_nxt};
    ch_mask   = (CNT_W'(1) << ch_shift) - CNT_W'(1);
    bit_mask  = (CNT_W'(1) << bit_shift) - CNT_W'(1);
    ch_start  = (slot_nxt & ch_mask) == '0;
    bit_start = (slot_nxt & bit_mask) == '0;
    ch_full   = slot_nxt >> ch_shift;
  end

  assign req_valid = run_nxt & legal_nxt & ch_start;
  assign req_chan  = ch_full[CHW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (req_valid) begin
      sh_q <= rsp_valid ? rsp_data : '0;
      oe_q <= rsp_valid & rsp_oe;
    end else if (!legal_nxt || !run_nxt) begin
      oe_q <= 1'b0;
    end else if (bit_start) begin
      sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign ser_oe = oe_q;
  assign ser_o  = oe_q & sh_q[BYTE_W-1];
endmodule

// File: rtl/tdm_mrate_tx.sv
module tdm_mrate_tx #(
  parameter int unsigned N_STR   = 4,
  parameter int unsigned BASE_CH = 2,
  parameter int unsigned HZ_N    = N_STR / 2,
  localparam int unsigned CNT_W  = $clog2(BASE_CH * tdm_tx_pkg::SLOTS_PER_BASE_CH),
  localparam int unsigned CHW    = $clog2(BASE_CH * 8)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_i,
  input  logic                  div_mode,
  input  logic [1:0]            ckin_code,
  input  logic [4*N_STR-1:0]    rate_cfg,
  output logic [N_STR-1:0]      req_valid,
  output logic [CHW*N_STR-1:0]  req_chan,
  input  logic [N_STR-1:0]      rsp_valid,
  input  logic [8*N_STR-1:0]    rsp_data,
  input  logic [N_STR-1:0]      rsp_oe,
  output logic [N_STR-1:0]      ser_o,
  output logic [N_STR-1:0]      ser_oe,
  output logic [HZ_N-1:0]       hz_o
);
  import tdm_tx_pkg::*;

  logic [4*N_STR-1:0] rate_q, rate_nxt;
  logic               div_q, div_nxt;
  logic [1:0]         ck_q, ck_nxt;
  logic [CNT_W-1:0]   slot_nxt;
  logic               run_nxt;

  // configuration is taken only with the frame pulse
  assign rate_nxt = frame_i ? rate_cfg  : rate_q;
  assign div_nxt  = frame_i ? div_mode  : div_q;
  assign ck_nxt   = frame_i ? ckin_code : ck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      div_q  <= 1'b0;
      ck_q   <= 2'd0;
    end else if (frame_i) begin
      rate_q <= rate_cfg;
      div_q  <= div_mode;
      ck_q   <= ckin_code;
    end
  end

  tdm_slot_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
    .slot_nxt(slot_nxt), .run_nxt(run_nxt)
  );

  for (genvar s = 0; s < N_STR; s++) begin : g_lane
    rate_code_t code_s;
    logic       legal_s;
    assign code_s  = rate_nxt[s*CODE_W +: CODE_W];
    assign legal_s = rate_legal(code_s, div_nxt, ck_nxt);

    tdm_tx_lane #(.CNT_W(CNT_W), .CHW(CHW)) lane_i (
      .clk(clk), .rst_n(rst_n), .run_nxt(run_nxt), .slot_nxt(slot_nxt),
      .rate_nxt(code_s[1:0]), .legal_nxt(legal_s),
      .req_valid(req_valid[s]), .req_chan(req_chan[s*CHW +: CHW]),
      .rsp_valid(rsp_valid[s]), .rsp_data(rsp_data[s*BYTE_W +: BYTE_W]),
      .rsp_oe(rsp_oe[s]), .ser_o(ser_o[s]), .ser_oe(ser_oe[s])
    );
  end

  for (genvar h = 0; h < HZ_N; h++) begin : g_hz
    assign hz_o[h] = ~ser_oe[h];
  end
endmodule

// File: rtl/tdm_mrate_tx_chk.sv
module tdm_mrate_tx_chk #(
  parameter int unsigned N_STR   = 4,
  parameter int unsigned BASE_CH = 2,
  parameter int unsigned HZ_N    = N_STR / 2,
  localparam int unsigned CHW    = $clog2(BASE_CH * 8)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_i,
  input logic                 div_mode,
  input logic [1:0]           ckin_code,
  input logic [4*N_STR-1:0]   rate_cfg,
  input logic [N_STR-1:0]     req_valid,
  input logic [CHW*N_STR-1:0] req_chan,
  input logic [N_STR-1:0]     rsp_valid,
  input logic [8*N_STR-1:0]   rsp_data,
  input logic [N_STR-1:0]     rsp_oe,
  input logic [N_STR-1:0]     ser_o,
  input logic [N_STR-1:0]     ser_oe,
  input logic [HZ_N-1:0]      hz_o
);
  logic unused_bits;
  assign unused_bits = ^rsp_data;

  for (genvar s = 0; s < N_STR; s++) begin : g_s
    // R3: channel 0 requested with the frame pulse when the code is legal
    a_r3_chan0_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_i && rate_cfg[s*4+3 -: 2] == 2'b00 && (!div_mode || rate_cfg[s*4 +: 2] <= ckin_code))
      |-> (req_valid[s] && req_chan[s*CHW +: CHW] == '0));
    // R4: first bit after a good load is the byte's MSB
    a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[s] && rsp_valid[s] && rsp_oe[s]) |=> (ser_oe[s] && ser_o[s] == $past(rsp_data[s*8+7])));
    // R5, R6: disabled or missing response leaves the channel undriven
    a_r5_r6_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[s] && !(rsp_valid[s] && rsp_oe[s])) |=> !ser_oe[s]);
    // R7: divided-mode rate above the input clock limit is never requested
    a_r7_div_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_i && div_mode && rate_cfg[s*4 +: 2] > ckin_code) |-> !req_valid[s]);
    // R8: codes 4..15 never raise a request
    a_r8_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_i && rate_cfg[s*4+3 -: 2] != 2'b00) |-> !req_valid[s]);
    // R1: drive can only start on a request
    a_r1_drive_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_oe[s]) |-> $past(req_valid[s]));
    // R5: no data while undriven
    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_oe[s] |-> !ser_o[s]);
  end

  for (genvar h = 0; h < HZ_N; h++) begin : g_h
    // R10: tristate control tracks the lane's enable
    a_r10_hz_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_oe[h]) |-> $fell(hz_o[h]));
  end
endmodule

bind tdm_mrate_tx tdm_mrate_tx_chk #(.N_STR(N_STR), .BASE_CH(BASE_CH), .HZ_N(HZ_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .div_mode(div_mode), .ckin_code(ckin_code),
  .rate_cfg(rate_cfg), .req_valid(req_valid), .req_chan(req_chan), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .rsp_oe(rsp_oe), .ser_o(ser_o), .ser_oe(ser_oe), .hz_o(hz_o)
);

// File: tb/tdm_mrate_tx_tb_top.sv
`timescale 1ns/1ps
module tdm_mrate_tx_tb_top;
  localparam int NS    = 4;
  localparam int BCH   = 2;
  localparam int HZN   = 2;
  localparam int CW    = 4;
  localparam int FRAME = BCH * 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_i;
  logic              div_mode;
  logic [1:0]        ckin_code;
  logic [4*NS-1:0]   rate_cfg;
  logic [NS-1:0]     req_valid;
  logic [CW*NS-1:0]  req_chan;
  logic [NS-1:0]     rsp_valid;
  logic [8*NS-1:0]   rsp_data;
  logic [NS-1:0]     rsp_oe;
  logic [NS-1:0]     ser_o;
  logic [NS-1:0]     ser_oe;
  logic [HZN-1:0]    hz_o;

  int errors = 0;
  int checks = 0;
  int fr_no  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  tdm_mrate_tx #(.N_STR(NS), .BASE_CH(BCH), .HZ_N(HZN)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .div_mode(div_mode), .ckin_code(ckin_code),
    .rate_cfg(rate_cfg), .req_valid(req_valid), .req_chan(req_chan), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_oe(rsp_oe), .ser_o(ser_o), .ser_oe(ser_oe), .hz_o(hz_o)
  );

  function automatic logic [7:0] f_data(int s, int ch, int fr);
    return 8'(((s * 37 + ch * 11 + fr * 53) & 255) ^ 8'hA5);
  endfunction
  function automatic bit f_vld(int s, int ch, int fr);
    return ((ch * 3 + s + fr) % 7) != 4;
  endfunction
  function automatic bit f_oen(int s, int ch, int fr);
    return ((ch + s + fr) % 5) != 3;
  endfunction
  function automatic bit f_legal(int code, bit dv, int ck);
    return (code < 4) && (!dv || code <= ck);
  endfunction

  // responder model: answers in the request cycle
  for (genvar s = 0; s < NS; s++) begin : g_rsp
    assign rsp_data[s*8 +: 8] = f_data(s, int'(req_chan[s*CW +: CW]), fr_no);
    assign rsp_valid[s]       = f_vld(s, int'(req_chan[s*CW +: CW]), fr_no);
    assign rsp_oe[s]          = f_oen(s, int'(req_chan[s*CW +: CW]), fr_no);
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // R2, R4, R5, R6, R7, R8, R10, R11: slot p of a frame
  task automatic chk_slot(int p, logic [4*NS-1:0] cfg, bit dv, int ck, int fr);
    for (int s = 0; s < NS; s++) begin
      int code = int'(cfg[s*4 +: 4]);
      bit lg   = f_legal(code, dv, ck);
      int r    = code & 3;
      int ch   = p >> (6 - r);
      int bt   = (p >> (3 - r)) & 7;
      bit eo   = lg && f_vld(s, ch, fr) && f_oen(s, ch, fr);
      logic [7:0] d = f_data(s, ch, fr);
      bit ed   = eo ? d[7 - bt] : 1'b0;
      check(ser_oe[s] == eo, "R5 R6 R7 R8 R11 ser_oe", int'(ser_oe[s]), int'(eo));
      check(ser_o[s] == ed, "R2 R4 ser_o bit", int'(ser_o[s]), int'(ed));
      if (s < HZN) check(hz_o[s] == !eo, "R10 hz_o", int'(hz_o[s]), int'(!eo));
    end
  endtask

  // R3, R7, R8: request for the slot starting next
  task automatic chk_req(int pn, logic [4*NS-1:0] cfg, bit dv, int ck);
    for (int s = 0; s < NS; s++) begin
      int code = int'(cfg[s*4 +: 4]);
      int r    = code & 3;
      bit ev   = f_legal(code, dv, ck) && ((pn % (64 >> r)) == 0);
      check(req_valid[s] == ev, "R3 R7 R8 req_valid", int'(req_valid[s]), int'(ev));
      if (ev) check(int'(req_chan[s*CW +: CW]) == (pn >> (6 - r)), "R3 req_chan",
                    int'(req_chan[s*CW +: CW]), pn >> (6 - r));
    end
  endtask

  initial begin
    logic [4*NS-1:0] cfg, pcfg;
    bit pdv;
    int pck, pfr;
    bit have_prev;
    rst_n = 1'b0; frame_i = 1'b0; div_mode = 1'b0; ckin_code = 2'd0; rate_cfg = '0;
    have_prev = 0; pcfg = '0; pdv = 0; pck = 0; pfr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      // R1: idle until the first frame pulse
      check(ser_oe == '0, "R1 ser_oe idle", int'(ser_oe), 0);
      check(hz_o == '1, "R1 hz_o idle", int'(hz_o), 3);
      check(req_valid == '0, "R1 req idle", int'(req_valid), 0);
    end
    for (int k = 0; k < 6; k++) begin
      for (int dv = 0; dv < 2; dv++) begin
        for (int ck = 0; ck < 4; ck++) begin
          bit scr = (k % 2) == 1;
          for (int s = 0; s < NS; s++) begin
            int c = (k + s) % 5;
            cfg[s*4 +: 4] = 4'((c == 4) ? 4 + k + ck : c);
          end
          @(negedge clk);
          fr_no = fr_no + 1;
          rate_cfg = cfg; div_mode = dv[0]; ckin_code = 2'(ck); frame_i = 1'b1;
          #1;
          if (have_prev) chk_slot(FRAME - 1, pcfg, pdv, pck, pfr);
          chk_req(0, cfg, dv[0], ck);
          for (int p = 0; p < FRAME - 1; p++) begin
            @(negedge clk);
            frame_i = 1'b0;
            // R9: mid-frame changes must not take effect
            if (scr && p == FRAME / 2) begin
              rate_cfg = ~cfg; div_mode = ~dv[0]; ckin_code = ~2'(ck);
            end
            #1;
            chk_slot(p, cfg, dv[0], ck, fr_no);
            chk_req(p + 1, cfg, dv[0], ck);
          end
          pcfg = cfg; pdv = dv[0]; pck = ck; pfr = fr_no; have_prev = 1;
        end
      end
    end
    @(negedge clk); #1;
    chk_slot(FRAME - 1, pcfg, pdv, pck, pfr);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule